// File: doc/BRIEF.md
# Byte-to-Word Packing Data FIFO Engine

This block sits between a 32-bit data register and a byte-wide card data stream. A 16-word circular buffer holds the words in flight. When a transfer runs towards the host, incoming card bytes are assembled into little-endian words and pushed into the buffer, and software pops them through the data register. When a transfer runs towards the card, software pushes words, and the engine pops them and hands their bytes to the card lowest byte first.

The length of a transfer is set in bytes. Writing the block-count input loads a down-counter with the product of that count and the stored block size. The engine moves at most one byte per clock under a valid/ready handshake, and it stops when the counter reaches zero. Sticky status flags record word movement by the engine and block boundaries. The fill level and a small transfer-state code are visible at all times.

Top module: `byte_pack_fifo`

## Requirements
- R1: The buffer holds up to 16 words and `fill_level` gives the current count. `data_wr` pushes `data_wdata` whenever `xfer_dir` is not read (2'b01). `data_rd` pops the head word whenever `xfer_dir` is not write (2'b10). `data_rdata` always shows the head word.
- R2: A push into a full buffer is dropped and leaves the contents unchanged. When the buffer is empty, `data_rdata` is zero and a pop leaves `fill_level` at zero.
- R3: A `blkcnt_wr` pulse loads the remaining byte count with `blkcnt_in` times the last block size latched by `blksz_wr`. Exactly that many bytes are then moved before the engine stops.
- R4: In read mode (`xfer_dir` = 2'b01), each accepted card byte is placed little-endian, with the first byte in bits 7:0, and a word is pushed on every fourth byte. `rx_ready` is low while the buffer is full or no bytes remain.
- R5: When the last byte of a transfer completes only part of a word, that word is still pushed, with its unused upper bytes zero.
- R6: In write mode (`xfer_dir` = 2'b10), each word popped by the engine is offered on `tx_byte` lowest byte first, and each accepted byte lowers the remaining count by one. `tx_byte` holds steady while `tx_valid` is high and `tx_ready` is low.
- R7: Each word pushed or popped by the engine sets `stat_data`. It also sets `stat_data_irq` when `data_irq_en` is high. Register pushes and pops set neither flag.
- R8: In write mode, with `blk_irq_en` high, `stat_blk_irq` is set when an accepted byte leaves the remaining count at a whole number of blocks.
- R9: `xfer_state` is 0 after reset and after a load of a nonzero count. It becomes 1 when an accepted byte brings the remaining count to zero.
- R10: The status flags are sticky. A high bit of `stat_clr` clears one flag: bit 0 clears `stat_data`, bit 1 clears `stat_data_irq`, bit 2 clears `stat_blk_irq`. A set in the same cycle wins over the clear.
- R11: In read mode `data_wr` has no effect, and in write mode `data_rd` does not pop.
- R12: After reset the buffer is empty, all flags are clear, `xfer_state` is 0, and neither `rx_ready` nor `tx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_dir | input | 2 | 01 read from card, 10 write to card, others idle |
| data_irq_en | input | 1 | Enables the data interrupt flag |
| blk_irq_en | input | 1 | Enables the block interrupt flag |
| blksz_wr | input | 1 | Latches the block size |
| blksz_in | input | 10 | Block size in bytes |
| blkcnt_wr | input | 1 | Loads the remaining count from the block count |
| blkcnt_in | input | 9 | Number of blocks |
| data_wr | input | 1 | Register push strobe |
| data_wdata | input | 32 | Word to push |
| data_rd | input | 1 | Register pop strobe |
| data_rdata | output | 32 | Head word, zero when empty |
| rx_byte | input | 8 | Byte from the card |
| rx_valid | input | 1 | Card byte present |
| rx_ready | output | 1 | Engine takes a card byte |
| tx_byte | output | 8 | Byte to the card |
| tx_valid | output | 1 | Byte to the card present |
| tx_ready | input | 1 | Card takes the byte |
| stat_clr | input | 3 | Per-flag clear mask |
| stat_data | output | 1 | Engine moved a word |
| stat_data_irq | output | 1 | Data interrupt flag |
| stat_blk_irq | output | 1 | Block interrupt flag |
| fill_level | output | 5 | Words held in the buffer |
| xfer_state | output | 4 | 0 idle or loaded, 1 count exhausted |

## Verification
Every state change lands on the clock edge that takes the strobe or completes the byte handshake. So pushes, pops, counter loads, flag updates and `xfer_state` are all visible one edge after the stimulus. The exception is write mode: the first `tx_byte` appears two edges after the word enters the buffer, one edge to fill the buffer and one for the engine to pop it. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each check sees exactly one rising edge's worth of change. The handshakes are resolved by reading `rx_ready` or `tx_valid` in the same half-cycle in which the byte is offered.

// File: rtl/bpk_pkg.sv
package bpk_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'b00,
    DIR_RD   = 2'b01,
    DIR_WR   = 2'b10,
    DIR_BOTH = 2'b11
  } dir_e;

  localparam logic [3:0] ST_IDLE = 4'h0;
  localparam logic [3:0] ST_DONE = 4'h1;

  localparam int BYTE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_W  = BYTE_W * LANES;

endpackage

// File: rtl/bpk_rst_sync.sv
module bpk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bpk_word_fifo.sv
module bpk_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic [AW:0]   fill,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] head_q, head_d;
  logic [AW:0]   len_q, len_d;
  logic          do_push, do_pop;
  logic [AW-1:0] wr_idx;

  assign full   = (len_q == (AW+1)'(DEPTH));
  assign empty  = (len_q == '0);
  assign fill   = len_q;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign wr_idx  = head_q + len_q[AW-1:0];

  always_comb begin
    head_d = head_q;
    len_d  = len_q;
    if (do_pop) head_d = head_q + 1'b1;
    len_d = len_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      len_q  <= '0;
    end else begin
      head_q <= head_d;
      len_q  <= len_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_idx == AW'(gi))) mem[gi] <= push_data;
    end
  end

  assign head_data = empty ? '0 : mem[head_q];
endmodule

// File: rtl/bpk_rx_packer.sv
module bpk_rx_packer
  import bpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              last,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              push,
  output logic [WORD_W-1:0] word_out
);
  localparam int ACC_W = WORD_W - BYTE_W;
  localparam int CW    = $clog2(LANES);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [WORD_W-1:0] merged;
  logic [4:0]        sh;

  assign sh = {cnt_q, 3'b000};

  always_comb begin
    merged = {{BYTE_W{1'b0}}, acc_q};
    merged[sh +: BYTE_W] = byte_in;
  end

  assign push     = take && ((cnt_q == CW'(LANES - 1)) || last);
  assign word_out = merged;

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clr || push) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (take) begin
      acc_d = merged[ACC_W-1:0];
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bpk_tx_unpacker.sv
module bpk_tx_unpacker
  import bpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic [BYTE_W-1:0] byte_out,
  output logic              has_byte
);
  localparam int LW = $clog2(LANES) + 1;

  logic [WORD_W-1:0] wd_q, wd_d;
  logic [LW-1:0]     left_q, left_d;

  assign has_byte = (left_q != '0);
  assign byte_out = wd_q[BYTE_W-1:0];

  always_comb begin
    wd_d   = wd_q;
    left_d = left_q;
    if (clr) begin
      wd_d   = '0;
      left_d = '0;
    end else if (load) begin
      wd_d   = load_word;
      left_d = LW'(LANES);
    end else if (shift) begin
      wd_d   = wd_q >> BYTE_W;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q   <= '0;
      left_q <= '0;
    end else begin
      wd_q   <= wd_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/byte_pack_fifo.sv
module byte_pack_fifo
  import bpk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SZ_W  = 10,
  parameter int BC_W  = 9,
  localparam int FILL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        xfer_dir,
  input  logic              data_irq_en,
  input  logic              blk_irq_en,
  input  logic              blksz_wr,
  input  logic [SZ_W-1:0]   blksz_in,
  input  logic              blkcnt_wr,
  input  logic [BC_W-1:0]   blkcnt_in,
  input  logic              data_wr,
  input  logic [31:0]       data_wdata,
  input  logic              data_rd,
  output logic [31:0]       data_rdata,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [2:0]        stat_clr,
  output logic              stat_data,
  output logic              stat_data_irq,
  output logic              stat_blk_irq,
  output logic [FILL_W-1:0] fill_level,
  output logic [3:0]        xfer_state
);
  localparam int CNT_W = SZ_W + BC_W;

  logic rst_i_n;
  bpk_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // direction decode
  logic is_rd, is_wr;
  assign is_rd = (xfer_dir == DIR_RD);
  assign is_wr = (xfer_dir == DIR_WR);

  // counters and flags
  logic [CNT_W-1:0] rem_q, rem_d, load_cnt;
  logic [SZ_W-1:0]  blk_left_q, blk_left_d;
  logic [SZ_W-1:0]  blksz_q, blksz_d;
  logic [3:0]       state_q, state_d;
  logic             f_data_q, f_data_d;
  logic             f_dirq_q, f_dirq_d;
  logic             f_blk_q, f_blk_d;

  // buffer and lane signals
  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [WORD_W-1:0] fifo_wdata, fifo_head;
  logic [FILL_W-1:0] fifo_fill;
  logic              pk_push;
  logic [WORD_W-1:0] pk_word;
  logic              up_has;
  logic [BYTE_W-1:0] up_byte;

  logic rem_nz, rx_take, rx_last, tx_fire, eng_pop, eng_push, step, blk_edge, word_evt;

  assign rem_nz   = (rem_q != '0);
  assign rx_ready = is_rd && rem_nz && !fifo_full;
  assign rx_take  = rx_ready && rx_valid;
  assign rx_last  = (rem_q == CNT_W'(1));
  assign tx_valid = is_wr && rem_nz && up_has;
  assign tx_fire  = tx_valid && tx_ready;
  assign eng_pop  = is_wr && rem_nz && !up_has && !fifo_empty;
  assign eng_push = is_rd && pk_push;
  assign step     = rx_take || tx_fire;
  assign blk_edge = tx_fire && (blk_left_q == SZ_W'(1));
  assign word_evt = eng_push || eng_pop;
  assign load_cnt = CNT_W'(blkcnt_in) * CNT_W'(blksz_q);

  assign fifo_push  = is_rd ? pk_push : data_wr;
  assign fifo_wdata = is_rd ? pk_word : data_wdata;
  assign fifo_pop   = is_wr ? eng_pop : data_rd;

  bpk_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .push      (fifo_push),
    .push_data (fifo_wdata),
    .pop       (fifo_pop),
    .head_data (fifo_head),
    .fill      (fifo_fill),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  bpk_rx_packer u_pack (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (blkcnt_wr),
    .take     (rx_take),
    .last     (rx_last),
    .byte_in  (rx_byte),
    .push     (pk_push),
    .word_out (pk_word)
  );

  bpk_tx_unpacker u_unpack (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clr       (blkcnt_wr),
    .load      (eng_pop),
    .load_word (fifo_head),
    .shift     (tx_fire),
    .byte_out  (up_byte),
    .has_byte  (up_has)
  );

  always_comb begin
    blksz_d    = blksz_wr ? blksz_in : blksz_q;
    rem_d      = rem_q;
    blk_left_d = blk_left_q;
    state_d    = state_q;
    if (blkcnt_wr) begin
      rem_d      = load_cnt;
      blk_left_d = blksz_q;
      if (load_cnt != '0) state_d = ST_IDLE;
    end else if (step) begin
      rem_d      = rem_q - 1'b1;
      blk_left_d = (blk_left_q == SZ_W'(1)) ? blksz_q : blk_left_q - 1'b1;
      if (rx_last) state_d = ST_DONE;
    end
    f_data_d = (f_data_q && !stat_clr[0]) || word_evt;
    f_dirq_d = (f_dirq_q && !stat_clr[1]) || (word_evt && data_irq_en);
    f_blk_d  = (f_blk_q  && !stat_clr[2]) || (blk_edge && blk_irq_en);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rem_q      <= '0;
      blk_left_q <= '0;
      blksz_q    <= '0;
      state_q    <= ST_IDLE;
      f_data_q   <= 1'b0;
      f_dirq_q   <= 1'b0;
      f_blk_q    <= 1'b0;
    end else begin
      rem_q      <= rem_d;
      blk_left_q <= blk_left_d;
      blksz_q    <= blksz_d;
      state_q    <= state_d;
      f_data_q   <= f_data_d;
      f_dirq_q   <= f_dirq_d;
      f_blk_q    <= f_blk_d;
    end
  end

  assign data_rdata    = fifo_head;
  assign tx_byte       = up_byte;
  assign stat_data     = f_data_q;
  assign stat_data_irq = f_dirq_q;
  assign stat_blk_irq  = f_blk_q;
  assign fill_level    = fifo_fill;
  assign xfer_state    = state_q;
endmodule

// File: rtl/bpk_checker.sv
module bpk_checker #(
  parameter int DEPTH = 16,
  localparam int FILL_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_byte,
  input logic              blkcnt_wr,
  input logic [2:0]        stat_clr,
  input logic              stat_data,
  input logic [FILL_W-1:0] fill_level
);
  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= FILL_W'(DEPTH));

  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == FILL_W'(DEPTH)) |-> !rx_ready);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !blkcnt_wr) |=> $stable(tx_byte));

  // R10
  data_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_data && !stat_clr[0]) |=> stat_data);

  // R1
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == $past(fill_level)) || (fill_level == $past(fill_level) + 1'b1) ||
    (fill_level + 1'b1 == $past(fill_level)));

  // R11
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));
endmodule

bind byte_pack_fifo bpk_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_byte    (tx_byte),
  .blkcnt_wr  (blkcnt_wr),
  .stat_clr   (stat_clr),
  .stat_data  (stat_data),
  .fill_level (fill_level)
);

// File: tb/byte_pack_fifo_test.sv
`timescale 1ns/1ps
module byte_pack_fifo_test;
  logic        clk;
  logic        rst_n;
  logic [1:0]  xfer_dir;
  logic        data_irq_en, blk_irq_en;
  logic        blksz_wr, blkcnt_wr;
  logic [9:0]  blksz_in;
  logic [8:0]  blkcnt_in;
  logic        data_wr, data_rd;
  logic [31:0] data_wdata, data_rdata;
  logic [7:0]  rx_byte, tx_byte;
  logic        rx_valid, rx_ready, tx_valid, tx_ready;
  logic [2:0]  stat_clr;
  logic        stat_data, stat_data_irq, stat_blk_irq;
  logic [4:0]  fill_level;
  logic [3:0]  xfer_state;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] got [0:15];
  int got_n;

  byte_pack_fifo uut (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  // block size, block count, first byte value
  localparam logic [26:0] RD_VEC [0:4] = '{
    {10'd4,  9'd1, 8'h10},
    {10'd6,  9'd1, 8'h20},
    {10'd3,  9'd3, 8'h30},
    {10'd5,  9'd1, 8'hF0},
    {10'd16, 9'd4, 8'h40}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] seed, input int w, input int n);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++)
      if (4*w + j < n) r[j*8 +: 8] = 8'(seed + 8'(4*w + j));
    return r;
  endfunction

  task automatic load_count(input int sz, input int cnt);
    @(negedge clk); blksz_in = 10'(sz); blksz_wr = 1;
    @(negedge clk); blksz_wr = 0; blkcnt_in = 9'(cnt); blkcnt_wr = 1;
    @(negedge clk); blkcnt_wr = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); stat_clr = 3'b111;
    @(negedge clk); stat_clr = 3'b000;
  endtask

  task automatic feed(input logic [7:0] seed, input int first, input int n);
    int i = first;
    int guard = 0;
    while (i < n && guard < 2000) begin
      @(negedge clk);
      rx_valid = 1; rx_byte = 8'(seed + 8'(i));
      if (rx_ready) i++;
      guard++;
    end
    if (i < n) chk("R3 feed stalled", 32'(i), 32'(n));
  endtask

  task automatic drain(input logic [7:0] seed, input int w0, input int w1, input int n);
    for (int w = w0; w < w1; w++) begin
      @(negedge clk);
      chk((w == w1 - 1 && n % 4 != 0) ? "R5 partial word" : "R4 packed word",
          data_rdata, exp_word(seed, w, n));
      data_rd = 1;
      @(negedge clk); data_rd = 0;
    end
  endtask

  task automatic collect(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (tx_valid && tx_ready && got_n < 16) begin
        got[got_n] = tx_byte;
        got_n++;
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; xfer_dir = 2'b00; data_irq_en = 0; blk_irq_en = 0;
    blksz_wr = 0; blkcnt_wr = 0; blksz_in = '0; blkcnt_in = '0;
    data_wr = 0; data_rd = 0; data_wdata = '0; rx_byte = '0; rx_valid = 0;
    tx_ready = 0; stat_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk("R12 fill", 32'(fill_level), 0);
    chk("R12 flags", {29'b0, stat_data, stat_data_irq, stat_blk_irq}, 0);
    chk("R12 state", 32'(xfer_state), 0);
    chk("R12 handshakes", {30'b0, rx_ready, tx_valid}, 0);
    chk("R2 empty head", data_rdata, 0);

    // read vectors
    data_irq_en = 1; blk_irq_en = 1;
    for (int v = 0; v < 5; v++) begin
      int sz = int'(RD_VEC[v][26:17]);
      int cn = int'(RD_VEC[v][16:8]);
      logic [7:0] sd = RD_VEC[v][7:0];
      int n = sz * cn;
      int nw = (n + 3) / 4;
      load_count(sz, cn);
      chk("R9 state after load", 32'(xfer_state), 0);
      clear_flags();
      @(negedge clk); xfer_dir = 2'b01;
      feed(sd, 0, n);
      @(negedge clk); rx_valid = 0;
      chk("R3 stop after count", 32'(rx_ready), 0);
      chk("R1 fill", 32'(fill_level), 32'(nw));
      chk("R9 done", 32'(xfer_state), 1);
      chk("R7 flags", {30'b0, stat_data, stat_data_irq}, 32'b11);
      if (v == 0) begin
        @(negedge clk); data_wdata = 32'hCAFE0001; data_wr = 1;
        @(negedge clk); data_wr = 0;
        chk("R11 write ignored in read", 32'(fill_level), 32'(nw));
        stat_clr = 3'b001;
        @(negedge clk); stat_clr = 3'b000;
        chk("R10 clear data only", {30'b0, stat_data, stat_data_irq}, 32'b01);
      end
      xfer_dir = 2'b00;
      drain(sd, 0, nw, n);
      @(negedge clk);
      chk("R2 empty after drain", data_rdata, 0);
      data_rd = 1;
      @(negedge clk); data_rd = 0;
      chk("R2 pop of empty", 32'(fill_level), 0);
    end

    // R4/R2 overflow: 68 bytes into 16 words
    load_count(17, 4);
    @(negedge clk); xfer_dir = 2'b01;
    feed(8'h00, 0, 64);
    @(negedge clk); rx_valid = 1; rx_byte = 8'h40;
    chk("R4 stall when full", 32'(rx_ready), 0);
    chk("R4 full", 32'(fill_level), 16);
    @(negedge clk); rx_valid = 0; xfer_dir = 2'b00;
    data_wdata = 32'hDEADBEEF; data_wr = 1;
    @(negedge clk); data_wr = 0;
    chk("R2 push into full", 32'(fill_level), 16);
    chk("R1 head", data_rdata, exp_word(8'h00, 0, 68));
    data_rd = 1;
    @(negedge clk); data_rd = 0; xfer_dir = 2'b01;
    feed(8'h00, 64, 68);
    @(negedge clk); rx_valid = 0;
    chk("R3 full count moved", 32'(xfer_state), 1);
    chk("R4 refilled", 32'(fill_level), 16);
    xfer_dir = 2'b00;
    drain(8'h00, 1, 17, 68);

    // R7 data interrupt disabled
    data_irq_en = 0;
    load_count(4, 1);
    clear_flags();
    @(negedge clk); xfer_dir = 2'b01;
    feed(8'h55, 0, 4);
    @(negedge clk); rx_valid = 0; xfer_dir = 2'b00;
    chk("R7 irq masked", {30'b0, stat_data, stat_data_irq}, 32'b10);
    drain(8'h55, 0, 1, 4);

    // write direction
    data_irq_en = 1; blk_irq_en = 1;
    load_count(8, 1);
    clear_flags();
    @(negedge clk); data_wdata = 32'hA4A3A2A1; data_wr = 1;
    @(negedge clk); data_wr = 0;
    chk("R1 register push", 32'(fill_level), 1);
    tx_ready = 0; xfer_dir = 2'b10;
    @(negedge clk);
    chk("R6 first byte", {24'b0, tx_byte}, 32'hA1);
    chk("R7 pop flags", {30'b0, stat_data, stat_data_irq}, 32'b11);
    chk("R6 engine pop", 32'(fill_level), 0);
    repeat (2) @(negedge clk);
    chk("R6 hold under stall", {23'b0, tx_valid, tx_byte}, 32'h1A1);
    tx_ready = 1; got_n = 0;
    if (tx_valid) begin got[0] = tx_byte; got_n = 1; end
    collect(8);
    chk("R6 byte count", 32'(got_n), 4);
    for (int k = 0; k < 4; k++) chk("R6 lsb first", 32'(got[k]), 32'(8'hA1 + 8'(k)));
    chk("R8 no mid-block flag", 32'(stat_blk_irq), 0);
    data_wdata = 32'hB4B3B2B1; data_wr = 1;
    @(negedge clk); data_wr = 0;
    got_n = 0;
    collect(10);
    chk("R3 remaining bytes", 32'(got_n), 4);
    for (int k = 0; k < 4; k++) chk("R6 second word", 32'(got[k]), 32'(8'hB1 + 8'(k)));
    chk("R8 block flag", 32'(stat_blk_irq), 1);
    chk("R9 write done", 32'(xfer_state), 1);

    // R11 pop blocked in write direction
    data_wdata = 32'h12345678; data_wr = 1;
    @(negedge clk); data_wr = 0; data_rd = 1;
    @(negedge clk); data_rd = 0;
    chk("R11 pop ignored in write", 32'(fill_level), 1);
    xfer_dir = 2'b00;
    @(negedge clk);
    chk("R1 word kept", data_rdata, 32'h12345678);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule